// File: doc/BRIEF.md
# Duplicate-Tag Snoop Filter for Private L1 Caches

This block keeps the private L1 data caches of a small CPU cluster coherent under the four-state MESI protocol. For every CPU it keeps a mirror of that CPU's L1 tags and line states. When a CPU misses, wants write permission, or drops a line, it raises a request. The block looks the address up in all the mirrors at once and sends snoop commands only to the caches that really hold the line. Whenever another cache can supply the line, the data moves directly between caches. The next-level memory port is used only when no cache holds the line, or when a dirty line is evicted.

The block serves one request at a time. Each CPU has its own request, response and snoop lines. The cache arrays themselves are outside the block. Each cache returns its line data on the snoop acknowledge, and passes a victim line with its eviction request. A CPU must ask for an upgrade before it writes to a line it holds Shared or Exclusive. Because of this, the mirrors always hold the exact state of each cache.

Top module: `dtag_snoop_unit`

## Requirements
- R1: There is one mirror per CPU, with one entry per L1 line. The set index is the low address bits and the tag is the high bits. After reset every entry is Invalid, so the first miss to any address goes to memory and causes no snoop.
- R2: A read miss (op code 0) that no other mirror holds makes exactly one memory read. The response state is Exclusive. State codes: I=0, S=1, E=2, M=3.
- R3: A snoop goes only to a CPU whose mirror holds the requested line. It never goes to the requester. A holder whose copy does not change gets no snoop. Snoop codes: 1 = invalidate, 2 = supply and keep Shared, 3 = supply and invalidate.
- R4: A read miss whose other holders are all clean sends code 2 to the lowest-numbered holder only. The line comes from that holder, with no memory access. The requester becomes Shared, and an Exclusive holder becomes Shared.
- R5: A read miss on a line that another CPU holds Modified sends code 3 to that owner. The requester takes the owner's data as Modified. The owner becomes Invalid, and memory is not touched.
- R6: A write miss (op code 1) invalidates every other holder. The lowest-numbered holder gets code 3 and supplies the data, and the others get code 1. With no holder the line is read from memory. In both cases the response is Modified.
- R7: An upgrade (op code 2) sends code 1 to every other holder and responds Modified. It makes no memory access.
- R8: An eviction (op code 3) sets the requester's matching mirror entry to Invalid and responds Invalid. If the mirror recorded Modified, the supplied victim data is written to memory once. Otherwise memory is not touched.
- R9: Requests are granted round-robin, starting after the last CPU served (CPU 0 first after reset). The grant is a one-cycle ready pulse. No further request is granted until the current response has been given.
- R10: Each transaction ends with a one-cycle response pulse to the requester only. No response, snoop, grant or memory request is active after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | NUM_CPU | Request raised, per CPU |
| reqReady | output | NUM_CPU | One-cycle grant, per CPU |
| reqOp | input | 2*NUM_CPU | Request code per CPU |
| reqAddr | input | ADDR_W*NUM_CPU | Line address per CPU |
| reqData | input | LINE_W*NUM_CPU | Victim line data per CPU (eviction) |
| rspValid | output | NUM_CPU | One-cycle completion, per CPU |
| rspState | output | 2 | Granted MESI state |
| rspData | output | LINE_W | Line data for misses |
| snpValid | output | NUM_CPU | Snoop command pending, per CPU |
| snpCmd | output | 2*NUM_CPU | Snoop code per CPU |
| snpAddr | output | ADDR_W | Snooped line address |
| snpAck | input | NUM_CPU | Snoop done, per CPU |
| snpData | input | LINE_W*NUM_CPU | Line data returned with the acknowledge |
| memReq | output | 1 | Next-level access pending |
| memWe | output | 1 | Access is a write |
| memAddr | output | ADDR_W | Next-level line address |
| memWdata | output | LINE_W | Write-back data |
| memAck | input | 1 | Next-level access done |
| memRdata | input | LINE_W | Next-level read data |

## Verification
The hardest states to reach from the ports are a Modified line that another CPU then reads, and an Exclusive holder that has to be demoted. Both need a particular chain of earlier requests from other CPUs. A pseudo-random walk over a tiny configuration (4 lines, 4 tags) reaches them. The bench keeps its own model of every cache. It chooses an upgrade or an eviction whenever its model shows the CPU already holds the line, and it forces conflict evictions before misses. A directed chain then walks one line from Exclusive through Shared, Modified, migration and write-back. Finally, all four CPUs request at once to show the round-robin order.

// File: rtl/dtag_snoop_pkg.sv
package dtag_snoop_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_t;
  typedef enum logic [1:0] {OP_RD = 2'd0, OP_WR = 2'd1, OP_UP = 2'd2, OP_EV = 2'd3} reqop_t;
  typedef enum logic [1:0] {SN_NONE = 2'd0, SN_INV = 2'd1, SN_SHARE = 2'd2, SN_MOVE = 2'd3} snpcmd_t;

  typedef struct packed {
    logic  capture;
    logic  loadMem;
    logic  commit;
    mesi_t commitState;
  } snoop_strobe_t;
endpackage

// File: rtl/dtag_snoop_dpath.sv
module dtag_snoop_dpath
  import dtag_snoop_pkg::*;
#(
  parameter  int NUM_CPU = 4,
  parameter  int LINES   = 8,
  parameter  int TAG_W   = 6,
  parameter  int LINE_W  = 32,
  localparam int CPU_W   = $clog2(NUM_CPU),
  localparam int IDX_W   = $clog2(LINES),
  localparam int ADDR_W  = TAG_W + IDX_W
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  snoop_strobe_t                 strb,
  input  logic [CPU_W-1:0]              grantIdx,
  input  logic [CPU_W-1:0]              reqCpu,
  input  logic [NUM_CPU*ADDR_W-1:0]     reqAddr,
  input  logic [NUM_CPU*LINE_W-1:0]     reqData,
  input  logic [NUM_CPU-1:0][1:0]       cmdVec,
  input  logic [NUM_CPU-1:0]            snpAck,
  input  logic [NUM_CPU*LINE_W-1:0]     snpData,
  input  logic [LINE_W-1:0]             memRdata,
  output logic [NUM_CPU-1:0][1:0]       holdState,
  output logic [ADDR_W-1:0]             curAddr,
  output logic [LINE_W-1:0]             curWdata,
  output logic [LINE_W-1:0]             lineData
);
  logic [TAG_W-1:0] curTag;
  logic [IDX_W-1:0] curIdx;
  assign curTag = curAddr[ADDR_W-1:IDX_W];
  assign curIdx = curAddr[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      curWdata <= '0;
      lineData <= '0;
    end else begin
      if (strb.capture) begin
        curAddr  <= reqAddr[grantIdx*ADDR_W +: ADDR_W];
        curWdata <= reqData[grantIdx*LINE_W +: LINE_W];
      end
      if (strb.loadMem) lineData <= memRdata;
      for (int i = 0; i < NUM_CPU; i++) begin
        if (snpAck[i] && cmdVec[i][1]) lineData <= snpData[i*LINE_W +: LINE_W];
      end
    end
  end

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_mirror
    logic [TAG_W-1:0] tagMem [LINES];
    mesi_t            stMem  [LINES];

    assign holdState[g] = (tagMem[curIdx] == curTag && stMem[curIdx] != ST_I) ? stMem[curIdx] : ST_I;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int s = 0; s < LINES; s++) begin
          tagMem[s] <= '0;
          stMem[s]  <= ST_I;
        end
      end else if (strb.commit) begin
        if (reqCpu == CPU_W'(g)) begin
          if (strb.commitState == ST_I) begin
            if (holdState[g] != ST_I) stMem[curIdx] <= ST_I;
          end else begin
            tagMem[curIdx] <= curTag;
            stMem[curIdx]  <= strb.commitState;
          end
        end else begin
          case (cmdVec[g])
            SN_INV, SN_MOVE: stMem[curIdx] <= ST_I;
            SN_SHARE:        stMem[curIdx] <= ST_S;
            default: ;
          endcase
        end
      end
    end
  end

  AST_MIRROR_TAKES_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit && strb.commitState != ST_I |=> holdState[$past(reqCpu)] == $past(strb.commitState)); // R1
  AST_EVICT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit && strb.commitState == ST_I |=> holdState[$past(reqCpu)] == ST_I); // R8
endmodule

// File: rtl/dtag_snoop_ctrl.sv
module dtag_snoop_ctrl
  import dtag_snoop_pkg::*;
#(
  parameter  int NUM_CPU = 4,
  localparam int CPU_W   = $clog2(NUM_CPU)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CPU-1:0]      reqValid,
  input  logic [NUM_CPU*2-1:0]    reqOp,
  output logic [NUM_CPU-1:0]      reqReady,
  input  logic [NUM_CPU-1:0][1:0] holdState,
  input  logic [NUM_CPU-1:0]      snpAck,
  input  logic                    memAck,
  output logic [NUM_CPU-1:0]      rspValid,
  output mesi_t                   rspState,
  output logic [NUM_CPU-1:0]      snpValid,
  output logic [NUM_CPU-1:0][1:0] cmdVec,
  output logic                    memReq,
  output logic                    memWe,
  output logic [CPU_W-1:0]        grantIdx,
  output logic [CPU_W-1:0]        reqCpu,
  output snoop_strobe_t           strb
);
  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_SNOOP, S_MEM, S_RESP} fsm_t;

  fsm_t               fsm;
  reqop_t             opReg;
  logic [CPU_W-1:0]   lastGrant;
  logic [NUM_CPU-1:0] pending;
  mesi_t              finalState;
  logic               memWrite;
  logic               grantHit;

  always_comb begin
    grantHit = 1'b0;
    grantIdx = '0;
    for (int k = NUM_CPU; k >= 1; k--) begin
      int c;
      c = (int'(lastGrant) + k) % NUM_CPU;
      if (reqValid[c]) begin
        grantHit = 1'b1;
        grantIdx = CPU_W'(c);
      end
    end
  end

  logic [NUM_CPU-1:0]      holders;
  logic                    anyM;
  logic [CPU_W-1:0]        supplier;
  logic [NUM_CPU-1:0][1:0] planCmd;
  logic [NUM_CPU-1:0]      planPend;
  mesi_t                   planState;
  logic                    planMem, planWe;

  always_comb begin
    holders  = '0;
    anyM     = 1'b0;
    supplier = '0;
    for (int i = NUM_CPU - 1; i >= 0; i--) begin
      if (CPU_W'(i) != reqCpu && holdState[i] != ST_I) begin
        holders[i] = 1'b1;
        supplier   = CPU_W'(i);
        if (holdState[i] == ST_M) anyM = 1'b1;
      end
    end
    planCmd   = '0;
    planState = ST_I;
    planMem   = 1'b0;
    planWe    = 1'b0;
    case (opReg)
      OP_RD: begin
        if (holders == '0) begin
          planMem   = 1'b1;
          planState = ST_E;
        end else begin
          planCmd[supplier] = anyM ? SN_MOVE : SN_SHARE;
          planState         = anyM ? ST_M : ST_S;
        end
      end
      OP_WR: begin
        for (int i = 0; i < NUM_CPU; i++) if (holders[i]) planCmd[i] = SN_INV;
        if (holders == '0) planMem = 1'b1;
        else planCmd[supplier] = SN_MOVE;
        planState = ST_M;
      end
      OP_UP: begin
        for (int i = 0; i < NUM_CPU; i++) if (holders[i]) planCmd[i] = SN_INV;
        planState = ST_M;
      end
      default: begin
        if (holdState[reqCpu] == ST_M) begin
          planMem = 1'b1;
          planWe  = 1'b1;
        end
      end
    endcase
    for (int i = 0; i < NUM_CPU; i++) planPend[i] = (planCmd[i] != SN_NONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsm        <= S_IDLE;
      opReg      <= OP_RD;
      lastGrant  <= CPU_W'(NUM_CPU - 1);
      reqCpu     <= '0;
      pending    <= '0;
      cmdVec     <= '0;
      finalState <= ST_I;
      memWrite   <= 1'b0;
    end else begin
      case (fsm)
        S_IDLE: if (grantHit) begin
          reqCpu    <= grantIdx;
          lastGrant <= grantIdx;
          opReg     <= reqop_t'(reqOp[grantIdx*2 +: 2]);
          fsm       <= S_LOOK;
        end
        S_LOOK: begin
          cmdVec     <= planCmd;
          pending    <= planPend;
          finalState <= planState;
          memWrite   <= planWe;
          fsm        <= (planPend != '0) ? S_SNOOP : (planMem ? S_MEM : S_RESP);
        end
        S_SNOOP: begin
          pending <= pending & ~snpAck;
          if ((pending & ~snpAck) == '0) fsm <= S_RESP;
        end
        S_MEM: if (memAck) fsm <= S_RESP;
        default: begin
          cmdVec   <= '0;
          memWrite <= 1'b0;
          fsm      <= S_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CPU; i++) begin
      reqReady[i] = (fsm == S_IDLE) && grantHit && (grantIdx == CPU_W'(i));
      rspValid[i] = (fsm == S_RESP) && (reqCpu == CPU_W'(i));
    end
  end
  assign snpValid          = (fsm == S_SNOOP) ? pending : '0;
  assign memReq            = (fsm == S_MEM);
  assign memWe             = memWrite;
  assign rspState          = finalState;
  assign strb.capture      = (fsm == S_IDLE) && grantHit;
  assign strb.loadMem      = (fsm == S_MEM) && memAck && !memWrite;
  assign strb.commit       = (fsm == S_RESP);
  assign strb.commitState  = finalState;

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_chk
    AST_SNOOP_ONLY_HOLDER: assert property (@(posedge clk) disable iff (!rstN)
      snpValid[g] |-> holdState[g] != ST_I); // R3
    AST_SHARE_FROM_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
      snpValid[g] && cmdVec[g] == SN_SHARE |-> holdState[g] != ST_M); // R4
  end
  AST_NO_SELF_SNOOP: assert property (@(posedge clk) disable iff (!rstN)
    snpValid != '0 |-> !snpValid[reqCpu]); // R3
  AST_MEMREAD_NO_HOLDER: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWe |-> holders == '0); // R2
  AST_UPGRADE_NO_MEM: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> opReg != OP_UP); // R7
  AST_WRITEBACK_DIRTY: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> opReg == OP_EV && holdState[reqCpu] == ST_M); // R8
  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    reqReady != '0 |=> reqReady == '0); // R9
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqReady)); // R9
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid != '0 |=> rspValid == '0); // R10
endmodule

// File: rtl/dtag_snoop_unit.sv
module dtag_snoop_unit
  import dtag_snoop_pkg::*;
#(
  parameter  int NUM_CPU = 4,
  parameter  int LINES   = 8,
  parameter  int TAG_W   = 6,
  parameter  int LINE_W  = 32,
  localparam int CPU_W   = $clog2(NUM_CPU),
  localparam int ADDR_W  = TAG_W + $clog2(LINES)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_CPU-1:0]        reqValid,
  output logic [NUM_CPU-1:0]        reqReady,
  input  logic [NUM_CPU*2-1:0]      reqOp,
  input  logic [NUM_CPU*ADDR_W-1:0] reqAddr,
  input  logic [NUM_CPU*LINE_W-1:0] reqData,
  output logic [NUM_CPU-1:0]        rspValid,
  output logic [1:0]                rspState,
  output logic [LINE_W-1:0]         rspData,
  output logic [NUM_CPU-1:0]        snpValid,
  output logic [NUM_CPU*2-1:0]      snpCmd,
  output logic [ADDR_W-1:0]         snpAddr,
  input  logic [NUM_CPU-1:0]        snpAck,
  input  logic [NUM_CPU*LINE_W-1:0] snpData,
  output logic                      memReq,
  output logic                      memWe,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [LINE_W-1:0]         memWdata,
  input  logic                      memAck,
  input  logic [LINE_W-1:0]         memRdata
);
  snoop_strobe_t           strb;
  logic [CPU_W-1:0]        grantIdx, reqCpu;
  logic [NUM_CPU-1:0][1:0] holdState, cmdVec;
  logic [ADDR_W-1:0]       curAddr;
  mesi_t                   rspStateE;

  dtag_snoop_ctrl #(.NUM_CPU(NUM_CPU)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqReady(reqReady),
    .holdState(holdState), .snpAck(snpAck), .memAck(memAck), .rspValid(rspValid),
    .rspState(rspStateE), .snpValid(snpValid), .cmdVec(cmdVec), .memReq(memReq),
    .memWe(memWe), .grantIdx(grantIdx), .reqCpu(reqCpu), .strb(strb)
  );

  dtag_snoop_dpath #(.NUM_CPU(NUM_CPU), .LINES(LINES), .TAG_W(TAG_W), .LINE_W(LINE_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .grantIdx(grantIdx), .reqCpu(reqCpu),
    .reqAddr(reqAddr), .reqData(reqData), .cmdVec(cmdVec), .snpAck(snpAck),
    .snpData(snpData), .memRdata(memRdata), .holdState(holdState), .curAddr(curAddr),
    .curWdata(memWdata), .lineData(rspData)
  );

  assign rspState = rspStateE;
  assign snpCmd   = cmdVec;
  assign snpAddr  = curAddr;
  assign memAddr  = curAddr;
endmodule

// File: tb/dtag_snoop_unit_tb_top.sv
`timescale 1ns/1ps
module dtag_snoop_unit_tb_top;
  localparam int NC = 4, LN = 4, TW = 2, LW = 32, AW = 4, NA = 16;

  logic clk = 1'b0, rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [NC-1:0]    reqValid = '0, snpAck = '0;
  logic [NC-1:0]    reqReady, rspValid, snpValid;
  logic [NC*2-1:0]  reqOp = '0;
  logic [NC*2-1:0]  snpCmd;
  logic [NC*AW-1:0] reqAddr = '0;
  logic [NC*LW-1:0] reqData = '0, snpData = '0;
  logic [1:0]       rspState;
  logic [LW-1:0]    rspData, memWdata;
  logic [LW-1:0]    memRdata = '0;
  logic [AW-1:0]    snpAddr, memAddr;
  logic             memReq, memWe;
  logic             memAck = 1'b0;

  dtag_snoop_unit #(.NUM_CPU(NC), .LINES(LN), .TAG_W(TW), .LINE_W(LW)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .rspValid(rspValid), .rspState(rspState),
    .rspData(rspData), .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
    .snpAck(snpAck), .snpData(snpData), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata)
  );

  int          cTag [NC][LN];
  int          cSt  [NC][LN];
  logic [31:0] cDat [NC][LN];
  logic [31:0] mem  [NA];
  logic [31:0] gVal [NA];
  int expCmd [NC];
  int snpCnt, snpErr, memRd, memWr;
  int checks = 0, errors = 0, lastSrv = NC - 1, opNum = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // cache-side snoop responder
  initial forever begin
    @(negedge clk);
    snpAck = '0;
    for (int i = 0; i < NC; i++) begin
      if (snpValid[i]) begin
        int ix, tg;
        ix = int'(snpAddr) % LN;
        tg = int'(snpAddr) / LN;
        snpCnt++;
        if (int'(snpCmd[i*2 +: 2]) != expCmd[i] || cSt[i][ix] == 0 || cTag[i][ix] != tg) snpErr++;
        snpAck[i] = 1'b1;
        snpData[i*LW +: LW] = cDat[i][ix];
        if (snpCmd[i*2 +: 2] == 2'd2) cSt[i][ix] = 1;
        else cSt[i][ix] = 0;
      end
    end
  end

  // next-level memory responder
  initial forever begin
    @(negedge clk);
    memAck = 1'b0;
    if (memReq) begin
      memAck = 1'b1;
      if (memWe) begin
        mem[memAddr] = memWdata;
        memWr++;
      end else begin
        memRdata = mem[memAddr];
        memRd++;
      end
    end
  end

  task automatic do_op(input int cpu, input int op, input int addr);
    int ix, tg, nh, sup, anyM, expRd, expWr, expSt, expSnp, n;
    string rq;
    ix = addr % LN; tg = addr / LN;
    nh = 0; sup = -1; anyM = 0; expRd = 0; expWr = 0; expSt = 0; expSnp = 0;
    for (int j = 0; j < NC; j++) expCmd[j] = 0;
    for (int j = NC - 1; j >= 0; j--)
      if (j != cpu && cSt[j][ix] != 0 && cTag[j][ix] == tg) begin
        nh++; sup = j;
        if (cSt[j][ix] == 3) anyM = 1;
      end
    case (op)
      0: begin
        if (nh == 0) begin expRd = 1; expSt = 2; rq = "R2"; end
        else if (anyM != 0) begin expCmd[sup] = 3; expSt = 3; rq = "R5"; end
        else begin expCmd[sup] = 2; expSt = 1; rq = "R4"; end
      end
      1: begin
        for (int j = 0; j < NC; j++)
          if (j != cpu && cSt[j][ix] != 0 && cTag[j][ix] == tg) expCmd[j] = 1;
        if (nh == 0) expRd = 1; else expCmd[sup] = 3;
        expSt = 3; rq = "R6";
      end
      2: begin
        for (int j = 0; j < NC; j++)
          if (j != cpu && cSt[j][ix] != 0 && cTag[j][ix] == tg) expCmd[j] = 1;
        expSt = 3; rq = "R7";
      end
      default: begin
        expWr = (cSt[cpu][ix] == 3 && cTag[cpu][ix] == tg) ? 1 : 0;
        rq = "R8";
      end
    endcase
    for (int j = 0; j < NC; j++) if (expCmd[j] != 0) expSnp++;
    snpCnt = 0; snpErr = 0; memRd = 0; memWr = 0;
    @(negedge clk);
    reqValid[cpu] = 1'b1;
    reqOp[cpu*2 +: 2] = 2'(op);
    reqAddr[cpu*AW +: AW] = AW'(addr);
    reqData[cpu*LW +: LW] = cDat[cpu][ix];
    #1;
    while (!reqReady[cpu]) begin @(negedge clk); #1; end
    @(negedge clk);
    reqValid[cpu] = 1'b0;
    n = 0;
    while (!rspValid[cpu] && n < 60) begin @(negedge clk); n++; end
    chk(rspValid[cpu], rq, "response seen", 32'(rspValid), 32'(1 << cpu));
    chk(int'(rspState) == expSt, rq, "response state", 32'(rspState), 32'(expSt));
    if (op <= 1) chk(rspData == gVal[addr], rq, "line data", rspData, gVal[addr]);
    @(negedge clk);
    chk(rspValid == '0, "R10", "response pulse width", 32'(rspValid), 0);
    chk(memRd == expRd, rq, "memory reads", 32'(memRd), 32'(expRd));
    chk(memWr == expWr, rq, "memory writes", 32'(memWr), 32'(expWr));
    chk(snpCnt == expSnp && snpErr == 0, "R3", "snoop targets", 32'(snpCnt * 256 + snpErr), 32'(expSnp * 256));
    if (expWr != 0) chk(mem[addr] == gVal[addr], "R8", "written back value", mem[addr], gVal[addr]);
    opNum++;
    lastSrv = cpu;
    if (op == 3) begin
      if (cTag[cpu][ix] == tg) cSt[cpu][ix] = 0;
    end else begin
      cTag[cpu][ix] = tg;
      cSt[cpu][ix] = expSt;
      if (op != 0) gVal[addr] = 32'h5000_0000 + 32'(opNum);
      cDat[cpu][ix] = gVal[addr];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] r;
    for (int a = 0; a < NA; a++) begin
      mem[a] = 32'hA000_0000 + 32'(a * 17);
      gVal[a] = mem[a];
    end
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < LN; s++) begin cTag[c][s] = 0; cSt[c][s] = 0; cDat[c][s] = '0; end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(rspValid == '0 && snpValid == '0, "R10", "idle after reset", 32'(rspValid | snpValid), 0);
    chk(reqReady == '0 && !memReq, "R10", "no grant or memory after reset", 32'(reqReady), 0);

    // R1: fresh mirrors, every CPU misses on its own line
    for (int c = 0; c < NC; c++) begin
      do_op(c, 0, 8 + c);
      chk(memRd == 1 && snpCnt == 0, "R1", "empty mirror lookup", 32'(memRd * 16 + snpCnt), 32'h10);
    end
    // directed chain on line 5: E -> S -> M -> migrate -> write back
    do_op(0, 0, 5);
    do_op(1, 0, 5);
    chk(cSt[0][1] == 1, "R4", "exclusive holder demoted", 32'(cSt[0][1]), 1);
    do_op(2, 0, 5);
    do_op(3, 1, 5);
    do_op(0, 0, 5);
    chk(cSt[3][1] == 0, "R5", "old owner invalid", 32'(cSt[3][1]), 0);
    do_op(1, 0, 5);
    do_op(1, 2, 5);
    do_op(1, 3, 5);

    // pseudo-random walk
    r = 16'hACE1;
    for (int it = 0; it < 700; it++) begin
      int cpu, addr, ix, tg;
      r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
      cpu = int'(r[1:0]); addr = int'(r[5:2]); ix = addr % LN; tg = addr / LN;
      if (r[8:7] == 2'd0 && cSt[cpu][ix] != 0) do_op(cpu, 3, cTag[cpu][ix] * LN + ix);
      else if (cSt[cpu][ix] != 0 && cTag[cpu][ix] == tg) do_op(cpu, (cSt[cpu][ix] == 3) ? 3 : 2, addr);
      else begin
        if (cSt[cpu][ix] != 0) do_op(cpu, 3, cTag[cpu][ix] * LN + ix);
        do_op(cpu, int'(r[6]), addr);
      end
    end

    // R9: all CPUs request together
    begin
      int accOrd[NC], rspOrd[NC];
      int nAcc, nRsp, guard;
      logic [NC-1:0] drop;
      nAcc = 0; nRsp = 0; guard = 0; drop = '0;
      @(negedge clk);
      for (int c = 0; c < NC; c++) begin
        int tg;
        tg = (cSt[c][0] != 0) ? (cTag[c][0] + 1) % NA / LN * 0 + ((cTag[c][0] + 1) % (NA / LN)) : 0;
        reqValid[c] = 1'b1;
        reqOp[c*2 +: 2] = 2'd3;
        reqAddr[c*AW +: AW] = AW'(tg * LN);
      end
      while (nRsp < NC && guard < 200) begin
        #1;
        for (int c = 0; c < NC; c++) begin
          if (reqReady[c] && nAcc < NC) begin accOrd[nAcc] = c; nAcc++; drop[c] = 1'b1; end
          if (rspValid[c] && nRsp < NC) begin
            rspOrd[nRsp] = c; nRsp++;
            chk(rspState == 2'd0, "R8", "evict of absent line", 32'(rspState), 0);
          end
        end
        @(negedge clk);
        reqValid = reqValid & ~drop;
        guard++;
      end
      for (int k = 0; k < NC; k++) begin
        int e;
        e = (lastSrv + 1 + k) % NC;
        chk(k < nAcc && accOrd[k] == e, "R9", "grant order", 32'(accOrd[k]), 32'(e));
        chk(k < nRsp && rspOrd[k] == e, "R9", "completion order", 32'(rspOrd[k]), 32'(e));
      end
    end

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule